// File: doc/BRIEF.md
# Program Association Section Parser

This block sits on the byte stream of a transport demultiplexer. Bytes arrive one per clock when `byte_valid` is high, and `pkt_start` marks the first byte of each 188-byte packet. The block keeps only packets whose packet ID matches the association-table ID and whose header says a new section starts inside them. From each such packet it rebuilds the association section, checks the common section header, and reports every program entry it holds.

Each entry comes out as a single-cycle strobe carrying the program number and its packet ID. Program number zero is a special entry. Its ID points to the network-information table rather than to a program map, and the `is_nit` flag marks it. The trailing checksum bytes are skipped without being checked. Only sections that fit inside one packet are handled. A section length that cannot fit in the rest of the packet raises a one-cycle error strobe.

The controller is one state machine. `ST_IDLE` waits for a packet start. A start byte equal to 0x47 moves to `ST_HDR1`, and any other start byte stays in `ST_IDLE`. From `ST_HDR1` the machine always moves to `ST_HDR2`. `ST_HDR2` moves to `ST_HDR3` when the ID matches and the start flag is set, and otherwise falls back to `ST_IDLE`. `ST_HDR3` always moves to `ST_PTR`. `ST_PTR` moves to `ST_TID` when the pointer is zero, and otherwise to `ST_SKIP`. `ST_SKIP` moves to `ST_TID` after the last skipped byte. `ST_TID` moves to `ST_LEN1` on a matching table ID and to `ST_IDLE` otherwise. `ST_LEN1` moves to `ST_LEN2` when the syntax bit is set and to `ST_IDLE` otherwise. `ST_LEN2` moves to `ST_EXT` when the length is legal, or to `ST_IDLE` with an error when it is not. `ST_EXT` moves to `ST_ENT`, or straight to `ST_CRC` when the section holds no entry bytes. `ST_ENT` moves to `ST_CRC` when only the checksum bytes remain. `ST_CRC` returns to `ST_IDLE` after the last checksum byte. Three global transitions override the per-state ones. A start byte in any state behaves as in `ST_IDLE`. The last byte of a packet always returns the machine to `ST_IDLE`. Bytes that arrive past the packet end, with no new start, are ignored.

Top module: `pat_section_parser`

## Requirements
- R1: After reset, `ent_valid` and `sec_err` are low, and no output strobe appears until a packet has been parsed.
- R2: A packet whose first byte is not 0x47 produces no entry and no error.
- R3: A packet whose 13-bit ID is not the table ID, or whose start flag is clear, produces nothing. The ID is bits 4:0 of byte 1 followed by all of byte 2, and the start flag is bit 6 of byte 1. Byte 3 is not interpreted.
- R4: Byte 4 is a pointer. That many bytes are skipped before the table ID byte. A pointer that runs to the end of the packet yields nothing.
- R5: A table ID byte other than 0x00 drops the section silently.
- R6: Bit 7 of the byte after the table ID is the syntax bit. When it is 0, the section is dropped with no entry and no error.
- R7: Each entry is 4 bytes. The first two bytes hold the program number, most significant byte first. The next two bytes hold 3 ignored bits and then a 13-bit ID. Each complete entry gives one `ent_valid` pulse in the cycle after its last byte is accepted, and entries come out in stream order.
- R8: `is_nit` is high with an entry exactly when its program number is zero.
- R9: The section length is 12 bits: bits 3:0 of the syntax byte followed by the next byte. It counts the bytes after itself. The first 5 of those bytes are skipped and the last 4 are ignored. The bytes in between form entries, and a trailing partial entry is discarded.
- R10: A length below 9, or a length larger than the number of bytes left in the packet after the length byte, gives one `sec_err` pulse in the cycle after the length's low byte and no entries.
- R11: A byte with `pkt_start` restarts parsing in any state and abandons a section in progress, while entries already reported stand. Bytes past byte 187 of a packet are ignored.
- R12: Cycles with `byte_valid` low change nothing, so idle gaps inside a packet do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_valid | input | 1 | A stream byte is present this cycle |
| pkt_start | input | 1 | This byte is the first of a packet |
| byte_in | input | 8 | Stream byte |
| ent_valid | output | 1 | One-cycle strobe for a program entry |
| prog_num | output | 16 | Program number of the entry |
| pid_out | output | 13 | Map-table or network-information ID |
| is_nit | output | 1 | Entry refers to the network-information table |
| sec_err | output | 1 | One-cycle strobe for an impossible section length |

## Verification
The bench builds the block with its default values: 188-byte packets, table ID 0x0000, table ID byte 0x00, a 5-byte extension and a 4-byte checksum. With these values a pointer of zero and a length of exactly 180 fill the packet to its final byte. That length yields 42 entries and a 3-byte partial entry, and a length of 181 is the first that must be rejected. Large pointers run the skip state into the forced return at the packet end. Random packets cover every header fault, the zero program number, idle gaps and trailing partial entries. A packet cut short by a new start checks that entries already reported survive while the rest of the section is abandoned.

// File: rtl/pat_pkg.sv
package pat_pkg;
    localparam logic [7:0] SYNC_BYTE = 8'h47;
    localparam int unsigned LEN_W = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR1,
        ST_HDR2,
        ST_HDR3,
        ST_PTR,
        ST_SKIP,
        ST_TID,
        ST_LEN1,
        ST_LEN2,
        ST_EXT,
        ST_ENT,
        ST_CRC
    } pat_state_t;
endpackage

// File: rtl/pat_pkt_tracker.sv
module pat_pkt_tracker #(
    parameter int unsigned PKT_LEN = 188,
    parameter int unsigned IDX_W   = $clog2(PKT_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             pkt_start,
    output logic [IDX_W-1:0] cur_idx,
    output logic             in_pkt
);
    logic [IDX_W-1:0] seen;

    // position of the byte on the bus within its packet
    assign cur_idx = pkt_start ? '0 : seen;
    assign in_pkt  = pkt_start || (seen < IDX_W'(PKT_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= IDX_W'(PKT_LEN);
        end else if (byte_valid && in_pkt) begin
            seen <= cur_idx + 1'b1;
        end
    end

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= IDX_W'(PKT_LEN));
endmodule

// File: rtl/pat_sec_fsm.sv
module pat_sec_fsm
    import pat_pkg::*;
#(
    parameter int unsigned PKT_LEN   = 188,
    parameter int unsigned IDX_W     = $clog2(PKT_LEN + 1),
    parameter logic [12:0] MAP_PID   = 13'h0000,
    parameter logic [7:0]  TABLE_ID  = 8'h00,
    parameter int unsigned EXT_LEN   = 5,
    parameter int unsigned CRC_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             pkt_start,
    input  logic [7:0]       byte_in,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic             in_pkt,
    output logic             ent_valid,
    output logic [15:0]      prog_num,
    output logic [12:0]      pid_out,
    output logic             is_nit,
    output logic             sec_err
);
    localparam int unsigned MIN_LEN = EXT_LEN + CRC_LEN;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

    pat_state_t       state, nxt;
    logic             pusi;
    logic [4:0]       pid_hi;
    logic [3:0]       len_hi;
    logic [7:0]       cnt;
    logic [LEN_W-1:0] rem;
    logic [1:0]       ebyte;
    logic [23:0]      ebuf;
    logic             err_n;

    logic             take;
    logic [LEN_W-1:0] len_w;
    logic [LEN_W:0]   room;
    logic [LEN_W-1:0] rem_dec;
    logic [12:0]      pid_w;

    assign take    = byte_valid && in_pkt && !pkt_start;
    assign len_w   = {len_hi, byte_in};
    assign room    = (LEN_W+1)'(PKT_LEN - 1) - (LEN_W+1)'(cur_idx);
    assign rem_dec = rem - 1'b1;
    assign pid_w   = {pid_hi, byte_in};

    // next state
    always_comb begin
        nxt   = state;
        err_n = 1'b0;
        if (byte_valid) begin
            if (pkt_start) begin
                nxt = (byte_in == SYNC_BYTE) ? ST_HDR1 : ST_IDLE;
            end else if (!in_pkt) begin
                nxt = ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: nxt = ST_IDLE;
                    ST_HDR1: nxt = ST_HDR2;
                    ST_HDR2: nxt = (pusi && pid_w == MAP_PID) ? ST_HDR3 : ST_IDLE;
                    ST_HDR3: nxt = ST_PTR;
                    ST_PTR:  nxt = (byte_in == 8'd0) ? ST_TID : ST_SKIP;
                    ST_SKIP: nxt = (cnt == 8'd1) ? ST_TID : ST_SKIP;
                    ST_TID:  nxt = (byte_in == TABLE_ID) ? ST_LEN1 : ST_IDLE;
                    ST_LEN1: nxt = byte_in[7] ? ST_LEN2 : ST_IDLE;
                    ST_LEN2: begin
                        if ((len_w < LEN_W'(MIN_LEN)) || ({1'b0, len_w} > room)) begin
                            nxt   = ST_IDLE;
                            err_n = 1'b1;
                        end else begin
                            nxt = ST_EXT;
                        end
                    end
                    ST_EXT: begin
                        if (cnt == 8'(EXT_LEN - 1))
                            nxt = (rem_dec == LEN_W'(CRC_LEN)) ? ST_CRC : ST_ENT;
                    end
                    ST_ENT:  if (rem_dec == LEN_W'(CRC_LEN)) nxt = ST_CRC;
                    ST_CRC:  if (rem_dec == '0) nxt = ST_IDLE;
                    default: nxt = ST_IDLE;
                endcase
                if (cur_idx == LAST_IDX) nxt = ST_IDLE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pusi      <= 1'b0;
            pid_hi    <= '0;
            len_hi    <= '0;
            cnt       <= '0;
            rem       <= '0;
            ebyte     <= '0;
            ebuf      <= '0;
            ent_valid <= 1'b0;
            prog_num  <= '0;
            pid_out   <= '0;
            is_nit    <= 1'b0;
            sec_err   <= 1'b0;
        end else begin
            ent_valid <= 1'b0;
            sec_err   <= err_n;
            if (take) begin
                unique case (state)
                    ST_HDR1: begin
                        pusi   <= byte_in[6];
                        pid_hi <= byte_in[4:0];
                    end
                    ST_PTR:  cnt <= byte_in;
                    ST_SKIP: cnt <= cnt - 1'b1;
                    ST_LEN1: len_hi <= byte_in[3:0];
                    ST_LEN2: begin
                        rem <= len_w;
                        cnt <= '0;
                    end
                    ST_EXT: begin
                        rem   <= rem_dec;
                        cnt   <= cnt + 1'b1;
                        ebyte <= '0;
                    end
                    ST_ENT: begin
                        rem   <= rem_dec;
                        ebyte <= ebyte + 1'b1;
                        ebuf  <= {ebuf[15:0], byte_in};
                        if (ebyte == 2'd3) begin
                            ent_valid <= 1'b1;
                            prog_num  <= ebuf[23:8];
                            pid_out   <= {ebuf[4:0], byte_in};
                            is_nit    <= (ebuf[23:8] == 16'd0);
                        end
                    end
                    ST_CRC:  rem <= rem_dec;
                    ST_IDLE, ST_HDR2, ST_HDR3, ST_TID: ;
                    default: ;
                endcase
            end
        end
    end

    assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ent_valid && sec_err));
    assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_err |=> !sec_err);
    assert_entry_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |=> !ent_valid);
    assert_nit_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> (is_nit == (prog_num == 16'd0)));
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(state));
endmodule

// File: rtl/pat_section_parser.sv
module pat_section_parser #(
    parameter int unsigned PKT_LEN  = 188,
    parameter logic [12:0] MAP_PID  = 13'h0000,
    parameter logic [7:0]  TABLE_ID = 8'h00,
    parameter int unsigned EXT_LEN  = 5,
    parameter int unsigned CRC_LEN  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic        pkt_start,
    input  logic [7:0]  byte_in,
    output logic        ent_valid,
    output logic [15:0] prog_num,
    output logic [12:0] pid_out,
    output logic        is_nit,
    output logic        sec_err
);
    localparam int unsigned IDX_W = $clog2(PKT_LEN + 1);

    logic [IDX_W-1:0] cur_idx;
    logic             in_pkt;

    pat_pkt_tracker #(
        .PKT_LEN(PKT_LEN),
        .IDX_W  (IDX_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .pkt_start (pkt_start),
        .cur_idx   (cur_idx),
        .in_pkt    (in_pkt)
    );

    pat_sec_fsm #(
        .PKT_LEN (PKT_LEN),
        .IDX_W   (IDX_W),
        .MAP_PID (MAP_PID),
        .TABLE_ID(TABLE_ID),
        .EXT_LEN (EXT_LEN),
        .CRC_LEN (CRC_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_valid(byte_valid),
        .pkt_start (pkt_start),
        .byte_in   (byte_in),
        .cur_idx   (cur_idx),
        .in_pkt    (in_pkt),
        .ent_valid (ent_valid),
        .prog_num  (prog_num),
        .pid_out   (pid_out),
        .is_nit    (is_nit),
        .sec_err   (sec_err)
    );
endmodule

// File: tb/sim_pat_section_parser.sv
module sim_pat_section_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic        pkt_start = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        ent_valid;
    logic [15:0] prog_num;
    logic [12:0] pid_out;
    logic        is_nit;
    logic        sec_err;

    int checks = 0;
    int failures = 0;

    logic [7:0] pkt [0:187];
    int exp_prog[$];
    int exp_pid[$];
    int obs_prog[$];
    int obs_pid[$];
    int obs_nit[$];
    int exp_err = 0;
    int obs_err = 0;

    always #10 clk = ~clk;

    pat_section_parser u0 (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .pkt_start(pkt_start),
        .byte_in(byte_in), .ent_valid(ent_valid), .prog_num(prog_num),
        .pid_out(pid_out), .is_nit(is_nit), .sec_err(sec_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (ent_valid) begin
                obs_prog.push_back(int'(prog_num));
                obs_pid.push_back(int'(pid_out));
                obs_nit.push_back(int'(is_nit));
            end
            if (sec_err) obs_err++;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected entries from the first nsent bytes of pkt, per the requirements
    task automatic model(input int nsent);
        int ptr;
        int len;
        int pid;
        if (pkt[0] != 8'h47) return;                       // R2
        pid = {pkt[1][4:0], pkt[2]};
        if (!pkt[1][6] || pid != 0) return;                // R3
        ptr = pkt[4];                                      // R4
        if (7 + ptr > 187 || 7 + ptr >= nsent) return;
        if (pkt[5 + ptr] != 8'h00) return;                 // R5
        if (!pkt[6 + ptr][7]) return;                      // R6
        len = {pkt[6 + ptr][3:0], pkt[7 + ptr]};           // R9
        if (len < 9 || len > 180 - ptr) begin              // R10
            exp_err++;
            return;
        end
        for (int k = 0; k < (len - 9) / 4; k++) begin
            int b;
            b = 13 + ptr + 4 * k;
            if (b + 3 < nsent) begin
                exp_prog.push_back(int'({pkt[b], pkt[b + 1]}));
                exp_pid.push_back(int'({pkt[b + 2][4:0], pkt[b + 3]}));
            end
        end
    endtask

    task automatic build(input logic [7:0] sync, input bit pusi, input int pid,
                         input int ptr, input logic [7:0] tid, input bit ssi, input int len);
        for (int i = 0; i < 188; i++) pkt[i] = 8'($urandom);
        pkt[0] = sync;
        pkt[1] = {1'b0, pusi, 1'b0, 5'(pid >> 8)};
        pkt[2] = 8'(pid);
        pkt[4] = 8'(ptr);
        if (ptr + 7 <= 187) begin
            pkt[5 + ptr] = tid;
            pkt[6 + ptr] = {ssi, pkt[6 + ptr][6:4], 4'(len >> 8)};
            pkt[7 + ptr] = 8'(len);
        end
        for (int i = 13 + ptr; i + 1 < 188; i += 4)
            if ($urandom % 5 == 0) begin
                pkt[i] = 8'h00;
                pkt[i + 1] = 8'h00;
            end
    endtask

    task automatic send(input int nsent, input bit gaps);
        for (int i = 0; i < nsent; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_in    = pkt[i];
            pkt_start  = (i == 0);
            if (gaps && ($urandom % 8 == 0)) begin
                @(negedge clk);
                byte_valid = 1'b0;
                pkt_start  = 1'b0;
                byte_in    = 8'($urandom);
            end
        end
        @(negedge clk);
        byte_valid = 1'b0;
        pkt_start  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        chk(tag, obs_prog.size(), exp_prog.size(), "entry count");
        chk("R10", obs_err, exp_err, {tag, " error count"});
        for (int k = 0; k < exp_prog.size() && k < obs_prog.size(); k++) begin
            chk("R7", obs_prog[k], exp_prog[k], {tag, " program number"});
            chk("R7", obs_pid[k], exp_pid[k], {tag, " entry id"});
            chk("R8", obs_nit[k], int'(exp_prog[k] == 0), {tag, " nit flag"});
        end
        exp_prog.delete(); exp_pid.delete();
        obs_prog.delete(); obs_pid.delete(); obs_nit.delete();
        exp_err = 0; obs_err = 0;
    endtask

    task automatic run(input string tag, input bit gaps);
        model(188);
        send(188, gaps);
        compare(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        process::self().srandom(32'd20240607);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", int'(ent_valid), 0, "ent_valid after reset");
        chk("R1", int'(sec_err), 0, "sec_err after reset");

        build(8'h47, 1, 0, 0, 8'h00, 1, 9 + 4 * 6);   run("R7", 0);
        build(8'h46, 1, 0, 0, 8'h00, 1, 9 + 4 * 6);   run("R2", 0);
        build(8'h47, 1, 5, 0, 8'h00, 1, 9 + 4 * 6);   run("R3", 0);
        build(8'h47, 0, 0, 0, 8'h00, 1, 9 + 4 * 6);   run("R3", 0);
        build(8'h47, 1, 0, 7, 8'h00, 1, 9 + 4 * 5);   run("R4", 0);
        build(8'h47, 1, 0, 200, 8'h00, 1, 20);         run("R4", 0);
        build(8'h47, 1, 0, 175, 8'h00, 1, 9);          run("R4", 0);
        build(8'h47, 1, 0, 0, 8'h02, 1, 9 + 4 * 6);   run("R5", 0);
        build(8'h47, 1, 0, 0, 8'h00, 0, 9 + 4 * 6);   run("R6", 0);
        build(8'h47, 1, 0, 0, 8'h00, 1, 180);         run("R9", 0);
        build(8'h47, 1, 0, 0, 8'h00, 1, 9 + 4 * 3 + 2); run("R9", 0);
        build(8'h47, 1, 0, 0, 8'h00, 1, 9);           run("R9", 0);
        build(8'h47, 1, 0, 0, 8'h00, 1, 181);         run("R10", 0);
        build(8'h47, 1, 0, 3, 8'h00, 1, 178);         run("R10", 0);
        build(8'h47, 1, 0, 0, 8'h00, 1, 8);           run("R10", 0);
        build(8'h47, 1, 0, 0, 8'h00, 1, 9 + 4 * 10);  run("R12", 1);

        // R11: a new start cuts a section short
        build(8'h47, 1, 0, 0, 8'h00, 1, 9 + 4 * 8);
        model(13 + 4 * 3 + 2);
        send(13 + 4 * 3 + 2, 0);
        build(8'h47, 1, 0, 2, 8'h00, 1, 9 + 4 * 4);
        model(188);
        send(188, 0);
        compare("R11");

        // R11: bytes past the packet end without a start are ignored
        build(8'h47, 1, 0, 0, 8'h00, 1, 9 + 4 * 2);
        model(188);
        send(188, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            pkt_start  = 1'b0;
            byte_in    = (i < 13) ? pkt[i] : 8'h00;
        end
        @(negedge clk);
        byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        compare("R11");

        for (int n = 0; n < 300; n++) begin
            int ptr;
            int ne;
            int len;
            ptr = ($urandom % 4 == 0) ? int'($urandom % 12) : 0;
            ne  = int'($urandom % 21);
            len = 9 + 4 * ne + (($urandom % 8 == 0) ? int'($urandom % 4) : 0);
            if ($urandom % 15 == 0)
                len = ($urandom % 2 == 0) ? (181 - ptr + int'($urandom % 20)) : int'($urandom % 9);
            build(($urandom % 10 == 0) ? 8'h40 + 8'($urandom % 7) : 8'h47,
                  ($urandom % 12 != 0),
                  ($urandom % 10 == 0) ? 1 + int'($urandom % 8190) : 0,
                  ptr,
                  ($urandom % 12 == 0) ? 8'h02 : 8'h00,
                  ($urandom % 12 != 0),
                  len);
            run("R7", ($urandom % 3 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule